// File: doc/BRIEF.md
# Drive Indicator Serial Shifter

The block drives a three-wire serial indicator link (shift clock, load marker, serial data) that carries per-drive activity, locate and fault lamps for up to eight drive ports. A one-cycle update strobe names a port and gives three lamp bits. The port number is passed through a programmable slot table, and the three bits land in a shared pattern register at the slot's position. Every accepted update then requests one serial frame. A frame holds, in this order: a configurable number of leading idle clocks, a single clock with the load marker raised, the pattern shifted out least significant bit first, and a configurable number of trailing idle clocks.

The serial clock runs at a fixed half period of 50 µs, derived from the system clock frequency parameter. A busy output covers the whole frame. Updates that arrive during a frame change the pattern register but leave the frame in flight untouched. They are all sent together in one following frame.

Top module: `drive_led_serializer`

## Requirements
- R1: After reset, sClk, sLoad and sData are all 1 and busy is 0.
- R2: An update for port p with bits {fault, locate, activity} writes pattern bits 3*s+0 (activity), 3*s+1 (locate) and 3*s+2 (fault), where s is the 3-bit field slotMap[3p+2:3p]. All other pattern bits stay as they were.
- R3: A frame has preClocks cycles with sLoad 0, then one cycle with sLoad 1, then 3*n data cycles carrying pattern bits 0, 1, 2, … in that order with sLoad 0, then postClocks cycles with sLoad 0. Here n is the active port count after R9.
- R4: Each serial clock cycle holds sClk at 1 for H system cycles and then at 0 for H system cycles, with H = CLK_HZ × HALF_US / 1e6. sClk falls only inside a frame.
- R5: sData changes only at a falling edge of sClk. Each data bit is presented at the falling edge before its own cycle and held through that cycle's high half.
- R6: A preClocks or postClocks value of 0 produces no leading or trailing cycles.
- R7: busy rises on the edge where sClk goes high for the first cycle of a frame. It stays 1 for exactly (cycles in frame) × 2H system cycles.
- R8: Updates accepted while busy is 1 do not alter the frame in progress. All of them appear together in exactly one following frame.
- R9: An activePorts value above MAX_PORTS is treated as MAX_PORTS. A value of 0 gives a frame with no data cycles.
- R10: When a frame ends, sClk and sLoad rest at 0 and sData keeps the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | One-cycle lamp update strobe |
| updPort | input | 3 | Port whose lamps change |
| updBits | input | 3 | {fault, locate, activity} for that port |
| activePorts | input | 4 | Number of ports carried per frame |
| preClocks | input | 8 | Leading idle clocks per frame |
| postClocks | input | 8 | Trailing idle clocks per frame |
| slotMap | input | 24 | Port-to-slot table, 3 bits per port, port p at [3p+2:3p] |
| sClk | output | 1 | Serial shift clock |
| sLoad | output | 1 | Load marker |
| sData | output | 1 | Serial data |
| busy | output | 1 | High while a frame is being sent |

## Verification
A slot-table or pattern-write fault shows up as a wrong bit in a known data cycle of the very next frame. A sequencing fault in the phase or cycle counters changes the number of cycles seen before or after the load-marked clock. It also changes the length of busy, so it shows within one frame. A half-period counter error changes the measured high or low time of the first full serial cycle. A merge fault shows as a first frame carrying late bits, a missing second frame, or a spurious third frame.

// File: rtl/ledser_pkg.sv
package ledser_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_LOAD, PH_DATA, PH_POST} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic snap;     // copy pattern into shifter
    logic clkHi;    // start a serial cycle
    logic clkLo;    // second half of a serial cycle
    logic loadLvl;  // load level for the cycle being started
    logic nextBit;  // present next data bit
    logic done;     // frame finished
  } strobe_t;
endpackage

// File: rtl/ledser_data.sv
module ledser_data
  import ledser_pkg::*;
#(
  parameter int MAX_PORTS = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           updValid,
  input  logic [$clog2(MAX_PORTS)-1:0]   updPort,
  input  logic [2:0]                     updBits,
  input  logic [MAX_PORTS*$clog2(MAX_PORTS)-1:0] slotMap,
  input  strobe_t                        stb,
  output logic                           sClk,
  output logic                           sLoad,
  output logic                           sData
);
  localparam int SLOT_W = $clog2(MAX_PORTS);
  localparam int PAT_W  = 3 * MAX_PORTS;

  logic [PAT_W-1:0]  pattern;
  logic [PAT_W-1:0]  shifter;
  logic [SLOT_W-1:0] updSlot;

  always_comb begin
    updSlot = '0;
    for (int p = 0; p < MAX_PORTS; p++)
      if (updPort == SLOT_W'(p)) updSlot = slotMap[p*SLOT_W +: SLOT_W];
  end

  for (genvar s = 0; s < MAX_PORTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) pattern[3*s +: 3] <= '0;
      else if (updValid && updSlot == SLOT_W'(s)) pattern[3*s +: 3] <= updBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter <= '0;
      sClk    <= 1'b1;
      sLoad   <= 1'b1;
      sData   <= 1'b1;
    end else begin
      if (stb.snap) shifter <= pattern;
      else if (stb.nextBit) shifter <= shifter >> 1;
      if (stb.nextBit) sData <= shifter[0];
      if (stb.clkHi) begin
        sClk  <= 1'b1;
        sLoad <= stb.loadLvl;
      end else if (stb.clkLo) sClk <= 1'b0;
      if (stb.done) sLoad <= 1'b0;
    end
  end

  // R5
  data_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sData) |-> !sClk);
endmodule

// File: rtl/ledser_ctrl.sv
module ledser_ctrl
  import ledser_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int HALF_CYC  = 10000,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         updValid,
  input  logic [$clog2(MAX_PORTS):0]   activePorts,
  input  logic [CNT_W-1:0]             preClocks,
  input  logic [CNT_W-1:0]             postClocks,
  output strobe_t                      stb,
  output logic                         busy
);
  localparam int AP_W   = $clog2(MAX_PORTS) + 1;
  localparam int BIT_W  = $clog2(3 * MAX_PORTS + 1);
  localparam int CYC_W  = (CNT_W > BIT_W) ? CNT_W : BIT_W;
  localparam int TICK_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  phase_e            phase, advPhase, startPhase, newPhase;
  logic [CYC_W-1:0]  cycLeft, advCnt, startCnt, nBits, nBitsR;
  logic [CNT_W-1:0]  postR;
  logic [TICK_W-1:0] tick;
  logic [AP_W-1:0]   clampPorts;
  logic hiHalf, pending, startNow, tickEnd, cycEnd, lastCyc;

  assign clampPorts = (activePorts > AP_W'(MAX_PORTS)) ? AP_W'(MAX_PORTS) : activePorts;
  assign nBits      = CYC_W'(clampPorts) * CYC_W'(3);
  assign startNow   = (phase == PH_IDLE) && pending;
  assign tickEnd    = (tick == TICK_W'(HALF_CYC - 1));
  assign cycEnd     = (phase != PH_IDLE) && tickEnd && !hiHalf;
  assign lastCyc    = (cycLeft == CYC_W'(1));
  assign busy       = (phase != PH_IDLE);

  always_comb begin
    advPhase = PH_IDLE;
    advCnt   = '0;
    case (phase)
      PH_PRE: begin advPhase = PH_LOAD; advCnt = CYC_W'(1); end
      PH_LOAD:
        if (nBitsR != '0) begin advPhase = PH_DATA; advCnt = nBitsR; end
        else if (postR != '0) begin advPhase = PH_POST; advCnt = CYC_W'(postR); end
      PH_DATA:
        if (postR != '0) begin advPhase = PH_POST; advCnt = CYC_W'(postR); end
      default: ;
    endcase
    if (preClocks != '0) begin startPhase = PH_PRE; startCnt = CYC_W'(preClocks); end
    else begin startPhase = PH_LOAD; startCnt = CYC_W'(1); end
  end

  always_comb begin
    newPhase    = startNow ? startPhase : (lastCyc ? advPhase : phase);
    stb         = '0;
    stb.snap    = startNow;
    stb.clkHi   = startNow || (cycEnd && (!lastCyc || advPhase != PH_IDLE));
    stb.clkLo   = (phase != PH_IDLE) && tickEnd && hiHalf;
    stb.loadLvl = (newPhase == PH_LOAD);
    stb.done    = cycEnd && lastCyc && (advPhase == PH_IDLE);
    stb.nextBit = stb.clkLo && (((phase == PH_LOAD) && (nBitsR != '0)) ||
                                ((phase == PH_DATA) && !lastCyc));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cycLeft <= '0;
      nBitsR  <= '0;
      postR   <= '0;
      tick    <= '0;
      hiHalf  <= 1'b0;
      pending <= 1'b0;
    end else begin
      pending <= updValid || (pending && !startNow);
      if (startNow) begin
        phase   <= startPhase;
        cycLeft <= startCnt;
        nBitsR  <= nBits;
        postR   <= postClocks;
        tick    <= '0;
        hiHalf  <= 1'b1;
      end else if (phase != PH_IDLE) begin
        if (tickEnd) begin
          tick <= '0;
          if (hiHalf) hiHalf <= 1'b0;
          else if (!lastCyc) begin
            cycLeft <= cycLeft - CYC_W'(1);
            hiHalf  <= 1'b1;
          end else begin
            phase   <= advPhase;
            cycLeft <= advCnt;
            hiHalf  <= 1'b1;
          end
        end else tick <= tick + TICK_W'(1);
      end
    end
  end

  // R8
  frame_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && pending) |=> (phase != PH_IDLE));
endmodule

// File: rtl/drive_led_serializer.sv
module drive_led_serializer
  import ledser_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int CLK_HZ    = 200_000_000,
  parameter int HALF_US   = 50,
  parameter int CNT_W     = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   updValid,
  input  logic [$clog2(MAX_PORTS)-1:0]           updPort,
  input  logic [2:0]                             updBits,
  input  logic [$clog2(MAX_PORTS):0]             activePorts,
  input  logic [CNT_W-1:0]                       preClocks,
  input  logic [CNT_W-1:0]                       postClocks,
  input  logic [MAX_PORTS*$clog2(MAX_PORTS)-1:0] slotMap,
  output logic                                   sClk,
  output logic                                   sLoad,
  output logic                                   sData,
  output logic                                   busy
);
  localparam int HALF_RAW = (CLK_HZ / 1000) * HALF_US / 1000;
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  strobe_t stb;

  ledser_ctrl #(.MAX_PORTS(MAX_PORTS), .HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .updValid(updValid), .activePorts(activePorts),
    .preClocks(preClocks), .postClocks(postClocks), .stb(stb), .busy(busy));

  ledser_data #(.MAX_PORTS(MAX_PORTS)) data_i (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updPort(updPort),
    .updBits(updBits), .slotMap(slotMap), .stb(stb),
    .sClk(sClk), .sLoad(sLoad), .sData(sData));

  // R7
  busy_starts_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> sClk);
  // R10
  rest_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!sClk && !sLoad));
  // R4
  fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sClk) |-> busy);
endmodule

// File: tb/drive_led_serializer_tb_top.sv
module drive_led_serializer_tb_top;
  localparam int H = 5;  // 100 kHz system clock parameter, 50 us half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic updValid = 1'b0;
  logic [2:0] updPort = '0;
  logic [2:0] updBits = '0;
  logic [3:0] activePorts = 4'd8;
  logic [7:0] preClocks = '0;
  logic [7:0] postClocks = '0;
  logic [23:0] slotMap;
  logic sClk, sLoad, sData, busy;

  always #2.5 clk = ~clk;  // 200 MHz

  drive_led_serializer #(.CLK_HZ(100_000), .HALF_US(50)) dut_i (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updPort(updPort),
    .updBits(updBits), .activePorts(activePorts), .preClocks(preClocks),
    .postClocks(postClocks), .slotMap(slotMap), .sClk(sClk), .sLoad(sLoad),
    .sData(sData), .busy(busy));

  int checks = 0, errors = 0;
  logic [23:0] modelPat = '0;

  // monitor
  logic prevClk = 1'b1, prevLoad = 1'b1, prevData = 1'b1, prevBusy = 1'b0;
  logic capLoad [0:63], capData [0:63], lastLoad [0:63], lastData [0:63];
  int capCnt = 0, lastCnt = 0, framesDone = 0, hiCnt = 0, loCnt = 0;
  int busyCnt = 0, lastBusyLen = 0, timingErr = 0, dataErr = 0;
  logic sawRise = 1'b0, lowBusy = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !prevBusy) begin capCnt = 0; busyCnt = 0; end
      if (busy) busyCnt++;
      if (prevClk && !sClk) begin
        if (capCnt < 64) begin capLoad[capCnt] = prevLoad; capData[capCnt] = prevData; end
        capCnt++;
        if (sawRise && hiCnt != H) timingErr++;
        loCnt = 0; lowBusy = 1'b1;
      end
      if (!prevClk && sClk) begin
        if (sawRise && lowBusy && loCnt != H) timingErr++;
        sawRise = 1'b1; hiCnt = 0;
      end
      if (sClk) hiCnt++; else loCnt++;
      if (!busy) lowBusy = 1'b0;
      if (sClk && prevClk && sData != prevData) dataErr++;
      if (!busy && prevBusy) begin
        lastCnt = capCnt; lastBusyLen = busyCnt;
        for (int i = 0; i < 64; i++) begin lastLoad[i] = capLoad[i]; lastData[i] = capData[i]; end
        framesDone++;
      end
      prevClk = sClk; prevLoad = sLoad; prevData = sData; prevBusy = busy;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doUpdate(input int port, input logic [2:0] bits);
    int slot;
    @(negedge clk);
    updValid = 1'b1; updPort = 3'(port); updBits = bits;
    @(negedge clk);
    updValid = 1'b0;
    slot = int'(slotMap[3*port +: 3]);
    modelPat[3*slot +: 3] = bits;
  endtask

  task automatic waitFrames(input int target);
    while (framesDone < target) @(negedge clk);
  endtask

  // compare last captured frame with expectation built from the requirements
  task automatic checkFrame(input string tag, input logic [23:0] pat,
                            input int pre, input int post, input int nports);
    int n, total, bad, badIdx;
    n = (nports > 8) ? 8 : nports;
    total = pre + 1 + 3 * n + post;
    chk(lastCnt == total, {tag, " R3 cycle count"}, lastCnt, total);
    bad = 0; badIdx = -1;
    for (int i = 0; i < total && i < 64; i++) begin
      logic expLoad;
      expLoad = (i == pre);
      if (lastLoad[i] != expLoad) begin bad++; if (badIdx < 0) badIdx = i; end
      if (i > pre && i <= pre + 3 * n)
        if (lastData[i] != pat[i - pre - 1]) begin bad++; if (badIdx < 0) badIdx = i; end
    end
    chk(bad == 0, {tag, " R2 R3 load/data order (first bad index)"}, badIdx, -1);
    chk(lastBusyLen == total * 2 * H, {tag, " R7 busy length"}, lastBusyLen, total * 2 * H);
    chk(timingErr == 0, {tag, " R4 half period"}, timingErr, 0);
    chk(dataErr == 0, {tag, " R5 data stable while clock high"}, dataErr, 0);
  endtask

  task automatic checkRest(input string tag, input logic lastBit, input bit hasData);
    chk(sClk == 1'b0 && sLoad == 1'b0, {tag, " R10 clock/load rest low"}, {sClk, sLoad}, 0);
    if (hasData) chk(sData == lastBit, {tag, " R10 data holds last bit"}, sData, lastBit);
  endtask

  task automatic testReset();
    chk(sClk && sLoad && sData, "R1 lines high after reset", {sClk, sLoad, sData}, 7);
    chk(!busy, "R1 busy low after reset", busy, 0);
  endtask

  task automatic testIdentity();
    int f;
    for (int p = 0; p < 8; p++) slotMap[3*p +: 3] = 3'(p);
    activePorts = 4'd8; preClocks = 0; postClocks = 0;
    f = framesDone;
    doUpdate(0, 3'b101);
    waitFrames(f + 1);
    checkFrame("identity R6", modelPat, 0, 0, 8);
    checkRest("identity", modelPat[23], 1'b1);
  endtask

  task automatic testRemap();
    int f;
    for (int p = 0; p < 8; p++) slotMap[3*p +: 3] = 3'(7 - p);
    activePorts = 4'd8; preClocks = 2; postClocks = 3;
    f = framesDone;
    doUpdate(5, 3'b011);
    waitFrames(f + 1);
    checkFrame("remap R2", modelPat, 2, 3, 8);
    chk(modelPat[8:6] == 3'b011, "R2 model slot 2 holds port 5", modelPat[8:6], 3);
  endtask

  task automatic testShortCount();
    int f;
    activePorts = 4'd2; preClocks = 1; postClocks = 0;
    f = framesDone;
    doUpdate(7, 3'b110);  // slot 0 under reversed map
    waitFrames(f + 1);
    checkFrame("two ports R3", modelPat, 1, 0, 2);
    checkRest("two ports", modelPat[5], 1'b1);
  endtask

  task automatic testClamp();
    int f;
    activePorts = 4'd12; preClocks = 0; postClocks = 1;
    f = framesDone;
    doUpdate(1, 3'b111);
    waitFrames(f + 1);
    checkFrame("clamp R9", modelPat, 0, 1, 12);
    activePorts = 4'd0; preClocks = 1; postClocks = 0;
    f = framesDone;
    doUpdate(2, 3'b010);
    waitFrames(f + 1);
    checkFrame("zero ports R9", modelPat, 1, 0, 0);
    checkRest("zero ports", 1'b0, 1'b0);
  endtask

  task automatic testMerge();
    int f;
    logic [23:0] snap1, snap2;
    activePorts = 4'd8; preClocks = 1; postClocks = 1;
    f = framesDone;
    doUpdate(2, 3'b110);
    snap1 = modelPat;
    while (!busy) @(negedge clk);
    repeat (30) @(negedge clk);
    doUpdate(3, 3'b001);
    doUpdate(4, 3'b100);
    snap2 = modelPat;
    waitFrames(f + 1);
    checkFrame("merge first R8", snap1, 1, 1, 8);
    waitFrames(f + 2);
    checkFrame("merge second R8", snap2, 1, 1, 8);
    repeat (400) @(negedge clk);
    chk(framesDone == f + 2, "R8 exactly one follow-up frame", framesDone - f, 2);
    chk(!busy, "R7 busy low when idle", busy, 0);
  endtask

  initial begin
    for (int p = 0; p < 8; p++) slotMap[3*p +: 3] = 3'(p);
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testIdentity();
    testRemap();
    testShortCount();
    testClamp();
    testMerge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", framesDone, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule